// File: doc/BRIEF.md
# Multi-Master Phased RAM Arbiter

This block places one fetch port, several CPU data ports, several DMA channels and one USB DMA port onto a shared set of on-chip RAM banks. Some banks are dual-phase: in each clock cycle they perform one access in an early phase and a second one in a late phase. The remaining banks are single-phase and perform one access per cycle. Each bank is arbitrated on its own, so masters that address different banks proceed in the same cycle.

Every request port is valid/ready. A request transfers in a cycle where valid and ready are both high, and ready is a combinational grant for that cycle. Fetch, CPU and USB requesters that see ready low must hold valid, address and data stable until the request is granted. DMA channels never wait. A DMA cycle with valid high and ready low is lost and is reported on `dma_drop`. Read responses have no back-pressure. A granted read returns its data one cycle later with a one-cycle `*_rvalid` strobe, and the receiver must take it in that cycle. The storage is a set of plain register arrays that clear on reset. Every address must select a bank that exists.

Top module: `ram_arb_top`

## Requirements
- R1: A valid fetch request is always granted in the same cycle, because fetch has the top priority and only reads.
- R2: The bank index is addr[AW-1:WW] and the word index is addr[WW-1:0]. With the defaults, bank = addr[5:4] and word = addr[3:0]. Banks 0..NDA-1 are dual-phase and banks NDA..NB-1 are single-phase. An access to one bank never alters another bank.
- R3: A dual-phase bank grants at most two requests per cycle. The winner gives the early phase and the runner-up gives the late phase. Any further requesters to that bank are not granted in that cycle.
- R4: A single-phase bank grants at most one request per cycle.
- R5: Priority is, from highest to lowest: fetch, then CPU ports with the lower index first, then DMA channels with the lower index first, then USB. A held, ungranted CPU or USB request is granted in a later cycle once higher-priority requesters have gone.
- R6: Within one cycle on a dual-phase bank, a late-phase read of the word written in the early phase returns the new data. An early-phase read of a word written in the late phase returns the old data. If both phases write the same word, the late-phase value remains.
- R7: Requests to different banks are granted in the same cycle, independently of one another.
- R8: The DMA channels share one path into the dual-phase group and one path into the single-phase group. At most one DMA channel is granted per group per cycle, and the lowest-indexed requester of a group takes that path.
- R9: A DMA request that is not granted is dropped. The cycle after, `dma_drop[i]` is high for exactly one cycle, no read data is returned, and no memory is written.
- R10: A USB request that addresses a dual-phase bank is consumed (usb_ready high) without any memory access. The next cycle, `usb_reject` pulses and `usb_rvalid` stays low.
- R11: After reset, all rvalid, drop and reject outputs are low and every memory word reads as zero.
- R12: A granted read raises that master's rvalid exactly one cycle later, carrying the addressed word. A granted write raises no rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch read request |
| fetch_ready | output | 1 | Fetch grant this cycle |
| fetch_addr | input | AW | Fetch address |
| fetch_rvalid | output | 1 | Fetch read data valid |
| fetch_rdata | output | DW | Fetch read data |
| cpu_valid | input | NCPU | CPU request per port |
| cpu_ready | output | NCPU | CPU grant per port |
| cpu_we | input | NCPU | CPU write enable per port |
| cpu_addr | input | NCPU x AW | CPU address per port |
| cpu_wdata | input | NCPU x DW | CPU write data per port |
| cpu_rvalid | output | NCPU | CPU read data valid per port |
| cpu_rdata | output | NCPU x DW | CPU read data per port |
| dma_valid | input | NDMA | DMA request per channel |
| dma_ready | output | NDMA | DMA grant per channel |
| dma_we | input | NDMA | DMA write enable per channel |
| dma_addr | input | NDMA x AW | DMA address per channel |
| dma_wdata | input | NDMA x DW | DMA write data per channel |
| dma_rvalid | output | NDMA | DMA read data valid per channel |
| dma_rdata | output | NDMA x DW | DMA read data per channel |
| dma_drop | output | NDMA | One-cycle pulse per channel whose request was lost |
| usb_valid | input | 1 | USB DMA request |
| usb_ready | output | 1 | USB grant or rejection this cycle |
| usb_we | input | 1 | USB write enable |
| usb_addr | input | AW | USB address |
| usb_wdata | input | DW | USB write data |
| usb_rvalid | output | 1 | USB read data valid |
| usb_rdata | output | DW | USB read data |
| usb_reject | output | 1 | Pulse after a USB request to a dual-phase bank |

## Verification
The two functions that collide most often are the early and late phases of one dual-phase bank, together with the DMA path limit. The bench drives several masters onto the same bank word in one cycle: a CPU write with a lower-priority CPU read, two CPU writes to one word, and an early read against a late write. It then judges the phase ordering from the read data returned one cycle later and from a later read-back. It also makes a DMA request lose either its group path or its bank in the same cycle as a granted CPU or fetch access. It checks both the drop pulse on the next cycle and, through a later read, that the lost write left memory untouched.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;
  // Phase in which a dual-phase bank serves a grant.
  typedef enum logic {
    PH_EARLY = 1'b0,
    PH_LATE  = 1'b1
  } phase_e;
endpackage

// File: rtl/ram_arb_dma_path.sv
// Picks at most one DMA channel per bank group (dual-phase / single-phase).
module ram_arb_dma_path #(
  parameter int NDMA = 2,
  parameter int NDA  = 2,
  parameter int BW   = 2
) (
  input  logic [NDMA-1:0]         req,
  input  logic [NDMA-1:0][BW-1:0] bank,
  output logic [NDMA-1:0]         pass
);
  always_comb begin
    logic da_taken;
    logic sa_taken;
    pass     = '0;
    da_taken = 1'b0;
    sa_taken = 1'b0;
    for (int i = 0; i < NDMA; i++) begin
      if (req[i]) begin
        if (int'(bank[i]) < NDA) begin
          if (!da_taken) pass[i] = 1'b1;
          da_taken = 1'b1;
        end else begin
          if (!sa_taken) pass[i] = 1'b1;
          sa_taken = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ram_arb_bank_arb.sv
// Fixed-priority picker for one bank: index 0 is the highest priority.
module ram_arb_bank_arb #(
  parameter int NM   = 6,
  parameter bit DUAL = 1'b1
) (
  input  logic [NM-1:0] req,
  output logic [NM-1:0] early_oh,
  output logic [NM-1:0] late_oh
);
  if (DUAL) begin : g_two
    always_comb begin
      logic he;
      logic hl;
      early_oh = '0;
      late_oh  = '0;
      he = 1'b0;
      hl = 1'b0;
      for (int m = 0; m < NM; m++) begin
        if (req[m]) begin
          if (!he) begin
            early_oh[m] = 1'b1;
            he = 1'b1;
          end else if (!hl) begin
            late_oh[m] = 1'b1;
            hl = 1'b1;
          end
        end
      end
    end
  end else begin : g_one
    always_comb begin
      logic he;
      early_oh = '0;
      he = 1'b0;
      for (int m = 0; m < NM; m++) begin
        if (req[m] && !he) begin
          early_oh[m] = 1'b1;
          he = 1'b1;
        end
      end
    end
    assign late_oh = '0;
  end
endmodule

// File: rtl/ram_arb_bank.sv
// Register-array bank; the dual variant runs an early then a late access per cycle.
module ram_arb_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter bit DUAL  = 1'b1,
  localparam int WW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          e_en,
  input  logic          e_we,
  input  logic [WW-1:0] e_addr,
  input  logic [DW-1:0] e_wdata,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [WW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] e_rdata,
  output logic [DW-1:0] l_rdata
);
  logic [DW-1:0] mem [DEPTH];

  if (DUAL) begin : g_dual
    logic [DW-1:0] late_view;
    // Late phase sees the early phase's write to the same word.
    assign late_view = (e_en && e_we && (e_addr == l_addr)) ? e_wdata : mem[l_addr];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        e_rdata <= '0;
        l_rdata <= '0;
      end else begin
        if (e_en) begin
          e_rdata <= mem[e_addr];
          if (e_we) mem[e_addr] <= e_wdata;
        end
        if (l_en) begin
          l_rdata <= late_view;
          if (l_we) mem[l_addr] <= l_wdata;  // later assignment wins
        end
      end
    end
  end else begin : g_single
    logic unused_late;
    assign unused_late = ^{l_en, l_we, l_addr, l_wdata};
    assign l_rdata = '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        e_rdata <= '0;
      end else if (e_en) begin
        e_rdata <= mem[e_addr];
        if (e_we) mem[e_addr] <= e_wdata;
      end
    end
  end
endmodule

// File: rtl/ram_arb_top.sv
module ram_arb_top #(
  parameter int NCPU  = 2,
  parameter int NDMA  = 2,
  parameter int NDA   = 2,
  parameter int NSA   = 2,
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int NB   = NDA + NSA,
  localparam int BW   = (NB > 1) ? $clog2(NB) : 1,
  localparam int WW   = $clog2(DEPTH),
  localparam int AW   = BW + WW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fetch_valid,
  output logic                      fetch_ready,
  input  logic [AW-1:0]             fetch_addr,
  output logic                      fetch_rvalid,
  output logic [DW-1:0]             fetch_rdata,
  input  logic [NCPU-1:0]           cpu_valid,
  output logic [NCPU-1:0]           cpu_ready,
  input  logic [NCPU-1:0]           cpu_we,
  input  logic [NCPU-1:0][AW-1:0]   cpu_addr,
  input  logic [NCPU-1:0][DW-1:0]   cpu_wdata,
  output logic [NCPU-1:0]           cpu_rvalid,
  output logic [NCPU-1:0][DW-1:0]   cpu_rdata,
  input  logic [NDMA-1:0]           dma_valid,
  output logic [NDMA-1:0]           dma_ready,
  input  logic [NDMA-1:0]           dma_we,
  input  logic [NDMA-1:0][AW-1:0]   dma_addr,
  input  logic [NDMA-1:0][DW-1:0]   dma_wdata,
  output logic [NDMA-1:0]           dma_rvalid,
  output logic [NDMA-1:0][DW-1:0]   dma_rdata,
  output logic [NDMA-1:0]           dma_drop,
  input  logic                      usb_valid,
  output logic                      usb_ready,
  input  logic                      usb_we,
  input  logic [AW-1:0]             usb_addr,
  input  logic [DW-1:0]             usb_wdata,
  output logic                      usb_rvalid,
  output logic [DW-1:0]             usb_rdata,
  output logic                      usb_reject
);
  import ram_arb_pkg::*;

  localparam int NM   = NCPU + NDMA + 2;
  localparam int CPU0 = 1;
  localparam int DMA0 = 1 + NCPU;
  localparam int USBI = NM - 1;

  // Unified master view, index = priority (0 highest).
  logic [NM-1:0]         m_valid, m_we, elig, grant, late_g;
  logic [NM-1:0][AW-1:0] m_addr;
  logic [NM-1:0][DW-1:0] m_wdata, m_rdata;
  logic [NM-1:0][BW-1:0] m_bank;

  always_comb begin
    m_valid[0] = fetch_valid;
    m_we[0]    = 1'b0;
    m_addr[0]  = fetch_addr;
    m_wdata[0] = '0;
    for (int i = 0; i < NCPU; i++) begin
      m_valid[CPU0+i] = cpu_valid[i];
      m_we[CPU0+i]    = cpu_we[i];
      m_addr[CPU0+i]  = cpu_addr[i];
      m_wdata[CPU0+i] = cpu_wdata[i];
    end
    for (int i = 0; i < NDMA; i++) begin
      m_valid[DMA0+i] = dma_valid[i];
      m_we[DMA0+i]    = dma_we[i];
      m_addr[DMA0+i]  = dma_addr[i];
      m_wdata[DMA0+i] = dma_wdata[i];
    end
    m_valid[USBI] = usb_valid;
    m_we[USBI]    = usb_we;
    m_addr[USBI]  = usb_addr;
    m_wdata[USBI] = usb_wdata;
    for (int m = 0; m < NM; m++) m_bank[m] = m_addr[m][AW-1:WW];
  end

  // DMA group paths.
  logic [NDMA-1:0][BW-1:0] dma_bank;
  logic [NDMA-1:0]         dma_pass;
  always_comb begin
    for (int i = 0; i < NDMA; i++) dma_bank[i] = m_bank[DMA0+i];
  end

  ram_arb_dma_path #(.NDMA(NDMA), .NDA(NDA), .BW(BW)) u_path (
    .req  (dma_valid),
    .bank (dma_bank),
    .pass (dma_pass)
  );

  logic usb_da;
  assign usb_da = usb_valid && (int'(m_bank[USBI]) < NDA);

  always_comb begin
    elig = m_valid;
    for (int i = 0; i < NDMA; i++) elig[DMA0+i] = dma_valid[i] && dma_pass[i];
    elig[USBI] = usb_valid && !usb_da;
  end

  // Per-bank arbitration and storage.
  logic [NM-1:0] e_oh_all [NB];
  logic [NM-1:0] l_oh_all [NB];
  logic [DW-1:0] bank_re  [NB];
  logic [DW-1:0] bank_rl  [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam bit IS_DUAL = (b < NDA) ? 1'b1 : 1'b0;
    logic [NM-1:0] req;
    logic          e_en, e_we, l_en, l_we;
    logic [WW-1:0] e_a, l_a;
    logic [DW-1:0] e_d, l_d;

    always_comb begin
      for (int m = 0; m < NM; m++) req[m] = elig[m] && (m_bank[m] == BW'(b));
    end

    ram_arb_bank_arb #(.NM(NM), .DUAL(IS_DUAL)) u_arb (
      .req      (req),
      .early_oh (e_oh_all[b]),
      .late_oh  (l_oh_all[b])
    );

    always_comb begin
      e_en = |e_oh_all[b];
      l_en = |l_oh_all[b];
      e_we = 1'b0; l_we = 1'b0;
      e_a  = '0;   l_a  = '0;
      e_d  = '0;   l_d  = '0;
      for (int m = 0; m < NM; m++) begin
        if (e_oh_all[b][m]) begin
          e_we = m_we[m]; e_a = m_addr[m][WW-1:0]; e_d = m_wdata[m];
        end
        if (l_oh_all[b][m]) begin
          l_we = m_we[m]; l_a = m_addr[m][WW-1:0]; l_d = m_wdata[m];
        end
      end
    end

    ram_arb_bank #(.DW(DW), .DEPTH(DEPTH), .DUAL(IS_DUAL)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .e_en    (e_en),
      .e_we    (e_we),
      .e_addr  (e_a),
      .e_wdata (e_d),
      .l_en    (l_en),
      .l_we    (l_we),
      .l_addr  (l_a),
      .l_wdata (l_d),
      .e_rdata (bank_re[b]),
      .l_rdata (bank_rl[b])
    );
  end

  always_comb begin
    grant  = '0;
    late_g = '0;
    for (int b = 0; b < NB; b++) begin
      grant  = grant | e_oh_all[b] | l_oh_all[b];
      late_g = late_g | l_oh_all[b];
    end
  end

  // Response tracking: one cycle after the grant.
  logic [NM-1:0]         rv_q;
  phase_e                rph_q   [NM];
  logic [NM-1:0][BW-1:0] rbank_q;
  logic [NDMA-1:0]       drop_q;
  logic                  reject_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q     <= '0;
      rbank_q  <= '0;
      drop_q   <= '0;
      reject_q <= 1'b0;
      for (int m = 0; m < NM; m++) rph_q[m] <= PH_EARLY;
    end else begin
      rv_q     <= grant & ~m_we;
      rbank_q  <= m_bank;
      reject_q <= usb_da;
      for (int m = 0; m < NM; m++) rph_q[m] <= late_g[m] ? PH_LATE : PH_EARLY;
      for (int i = 0; i < NDMA; i++) drop_q[i] <= dma_valid[i] && !grant[DMA0+i];
    end
  end

  always_comb begin
    for (int m = 0; m < NM; m++)
      m_rdata[m] = (rph_q[m] == PH_LATE) ? bank_rl[rbank_q[m]] : bank_re[rbank_q[m]];
  end

  // Port mapping.
  always_comb begin
    fetch_ready  = grant[0];
    fetch_rvalid = rv_q[0];
    fetch_rdata  = m_rdata[0];
    for (int i = 0; i < NCPU; i++) begin
      cpu_ready[i]  = grant[CPU0+i];
      cpu_rvalid[i] = rv_q[CPU0+i];
      cpu_rdata[i]  = m_rdata[CPU0+i];
    end
    for (int i = 0; i < NDMA; i++) begin
      dma_ready[i]  = grant[DMA0+i];
      dma_rvalid[i] = rv_q[DMA0+i];
      dma_rdata[i]  = m_rdata[DMA0+i];
    end
    dma_drop   = drop_q;
    usb_ready  = grant[USBI] || usb_da;
    usb_rvalid = rv_q[USBI];
    usb_rdata  = m_rdata[USBI];
    usb_reject = reject_q;
  end
endmodule

// File: rtl/ram_arb_chk.sv
module ram_arb_chk #(
  parameter int NCPU  = 2,
  parameter int NDMA  = 2,
  parameter int NDA   = 2,
  parameter int NSA   = 2,
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int NB   = NDA + NSA,
  localparam int BW   = (NB > 1) ? $clog2(NB) : 1,
  localparam int WW   = $clog2(DEPTH),
  localparam int AW   = BW + WW
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fetch_valid,
  input logic                    fetch_ready,
  input logic [AW-1:0]           fetch_addr,
  input logic                    fetch_rvalid,
  input logic [NCPU-1:0]         cpu_valid,
  input logic [NCPU-1:0]         cpu_ready,
  input logic [NCPU-1:0]         cpu_we,
  input logic [NCPU-1:0][AW-1:0] cpu_addr,
  input logic [NCPU-1:0]         cpu_rvalid,
  input logic [NDMA-1:0]         dma_valid,
  input logic [NDMA-1:0]         dma_ready,
  input logic [NDMA-1:0][AW-1:0] dma_addr,
  input logic [NDMA-1:0]         dma_drop,
  input logic                    usb_valid,
  input logic                    usb_ready,
  input logic [AW-1:0]           usb_addr,
  input logic                    usb_reject,
  input logic                    usb_rvalid
);
  logic usb_to_da;
  logic dma_group_ok;
  logic bank_load_ok;

  assign usb_to_da = usb_valid && (int'(usb_addr[AW-1:WW]) < NDA);

  always_comb begin
    int da_n, sa_n;
    da_n = 0; sa_n = 0;
    for (int i = 0; i < NDMA; i++) begin
      if (dma_valid[i] && dma_ready[i]) begin
        if (int'(dma_addr[i][AW-1:WW]) < NDA) da_n++;
        else sa_n++;
      end
    end
    dma_group_ok = (da_n <= 1) && (sa_n <= 1);
  end

  always_comb begin
    bank_load_ok = 1'b1;
    for (int b = 0; b < NB; b++) begin
      int n;
      n = 0;
      if (fetch_valid && fetch_ready && int'(fetch_addr[AW-1:WW]) == b) n++;
      for (int i = 0; i < NCPU; i++)
        if (cpu_valid[i] && cpu_ready[i] && int'(cpu_addr[i][AW-1:WW]) == b) n++;
      for (int i = 0; i < NDMA; i++)
        if (dma_valid[i] && dma_ready[i] && int'(dma_addr[i][AW-1:WW]) == b) n++;
      if (usb_valid && usb_ready && !usb_to_da && int'(usb_addr[AW-1:WW]) == b) n++;
      if (n > ((b < NDA) ? 2 : 1)) bank_load_ok = 1'b0;
    end
  end

  assert_fetch_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> fetch_ready);

  assert_fetch_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> fetch_rvalid);

  // R3 and R4: per-bank grant limits.
  assert_bank_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load_ok);

  assert_dma_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_group_ok);

  assert_usb_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    usb_to_da |=> usb_reject && !usb_rvalid);

  for (genvar i = 0; i < NDMA; i++) begin : g_dma
    assert_dma_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_valid[i] && !dma_ready[i] |=> dma_drop[i]);
    assert_dma_nodrop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(dma_valid[i] && !dma_ready[i]) |=> !dma_drop[i]);
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    assert_cpu_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid[i] && cpu_ready[i] && !cpu_we[i] |=> cpu_rvalid[i]);
    assert_cpu_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid[i] && cpu_ready[i] && cpu_we[i] |=> !cpu_rvalid[i]);
  end
endmodule

bind ram_arb_top ram_arb_chk #(
  .NCPU(NCPU), .NDMA(NDMA), .NDA(NDA), .NSA(NSA), .DEPTH(DEPTH), .DW(DW)
) u_chk (.*);

// File: tb/ram_arb_top_tb.sv
module ram_arb_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 2;
  localparam int NDMA = 2;
  localparam int DW   = 16;
  localparam int AW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                    fetch_valid, fetch_ready, fetch_rvalid;
  logic [AW-1:0]           fetch_addr;
  logic [DW-1:0]           fetch_rdata;
  logic [NCPU-1:0]         cpu_valid, cpu_ready, cpu_we, cpu_rvalid;
  logic [NCPU-1:0][AW-1:0] cpu_addr;
  logic [NCPU-1:0][DW-1:0] cpu_wdata, cpu_rdata;
  logic [NDMA-1:0]         dma_valid, dma_ready, dma_we, dma_rvalid, dma_drop;
  logic [NDMA-1:0][AW-1:0] dma_addr;
  logic [NDMA-1:0][DW-1:0] dma_wdata, dma_rdata;
  logic                    usb_valid, usb_ready, usb_we, usb_rvalid, usb_reject;
  logic [AW-1:0]           usb_addr;
  logic [DW-1:0]           usb_wdata, usb_rdata;

  ram_arb_top u_dut (.*);

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] A(input int b, input int w);
    return AW'(b * 16 + w);
  endfunction

  task automatic clr();
    fetch_valid = 0; fetch_addr = '0;
    cpu_valid = '0; cpu_we = '0; cpu_addr = '0; cpu_wdata = '0;
    dma_valid = '0; dma_we = '0; dma_addr = '0; dma_wdata = '0;
    usb_valid = 0; usb_we = 0; usb_addr = '0; usb_wdata = '0;
  endtask

  // Inputs change 1 time unit after a rising edge; combinational ready is sampled 1 unit later.
  task automatic settle(); #1; endtask
  task automatic step(); @(posedge clk); #1; endtask

  task automatic t_reset();
    chk("R11 rvalid after reset", {fetch_rvalid, cpu_rvalid, dma_rvalid, usb_rvalid}, 0);
    chk("R11 drop/reject after reset", {dma_drop, usb_reject}, 0);
    cpu_valid[0] = 1; cpu_addr[0] = A(0, 3);
    settle(); step(); clr();
    chk("R11 memory zero", cpu_rdata[0], 16'h0000);
  endtask

  task automatic t_dual_two();
    cpu_valid = 2'b11; cpu_we = 2'b11;
    cpu_addr[0] = A(0, 5); cpu_wdata[0] = 16'hA5A5;
    cpu_addr[1] = A(0, 6); cpu_wdata[1] = 16'h1234;
    settle(); chk("R3 two writes one dual bank", cpu_ready, 2'b11);
    step(); clr();
    chk("R12 no rvalid on write", cpu_rvalid, 2'b00);
    fetch_valid = 1; fetch_addr = A(0, 5);
    cpu_valid = 2'b11; cpu_addr[0] = A(0, 6); cpu_addr[1] = A(0, 5);
    settle();
    chk("R1 fetch granted", fetch_ready, 1);
    chk("R3 third requester stalled", cpu_ready, 2'b01);
    step();
    fetch_valid = 0; cpu_valid = 2'b10;
    chk("R12 fetch read data", {fetch_rvalid, fetch_rdata}, {1'b1, 16'hA5A5});
    chk("R12 cpu0 read data", {cpu_rvalid, cpu_rdata[0]}, {2'b01, 16'h1234});
    settle(); chk("R5 held cpu1 granted later", cpu_ready, 2'b10);
    step(); clr();
    chk("R12 cpu1 read data", {cpu_rvalid, cpu_rdata[1]}, {2'b10, 16'hA5A5});
  endtask

  task automatic t_phase_order();
    cpu_valid = 2'b11; cpu_we = 2'b01;
    cpu_addr[0] = A(1, 2); cpu_wdata[0] = 16'h0F0F; cpu_addr[1] = A(1, 2);
    settle(); step(); clr();
    chk("R6 late read sees early write", cpu_rdata[1], 16'h0F0F);
    cpu_valid = 2'b11; cpu_we = 2'b11;
    cpu_addr[0] = A(1, 3); cpu_wdata[0] = 16'h1111;
    cpu_addr[1] = A(1, 3); cpu_wdata[1] = 16'h2222;
    settle(); step(); clr();
    cpu_valid = 2'b11; cpu_we = 2'b10;
    cpu_addr[0] = A(1, 4); cpu_addr[1] = A(1, 4); cpu_wdata[1] = 16'h7777;
    settle(); chk("R6 read+write same word both granted", cpu_ready, 2'b11);
    step(); clr();
    chk("R6 early read sees old word", cpu_rdata[0], 16'h0000);
    fetch_valid = 1; fetch_addr = A(1, 3);
    cpu_valid = 2'b01; cpu_addr[0] = A(1, 4);
    settle(); step(); clr();
    chk("R6 late write wins", fetch_rdata, 16'h2222);
    chk("R6 late write stored", cpu_rdata[0], 16'h7777);
  endtask

  task automatic t_single();
    cpu_valid = 2'b11; cpu_we = 2'b11;
    cpu_addr[0] = A(2, 0); cpu_wdata[0] = 16'hBEEF;
    cpu_addr[1] = A(2, 1); cpu_wdata[1] = 16'hCAFE;
    dma_valid = 2'b01; dma_we = 2'b01; dma_addr[0] = A(3, 0); dma_wdata[0] = 16'h5555;
    settle();
    chk("R4 single bank one grant", cpu_ready, 2'b01);
    chk("R7 other bank granted in parallel", dma_ready, 2'b01);
    step();
    cpu_valid = 2'b10; dma_valid = '0;
    chk("R9 no drop when granted", dma_drop, 2'b00);
    settle(); chk("R4 stalled cpu1 granted next", cpu_ready, 2'b10);
    step(); clr();
    fetch_valid = 1; fetch_addr = A(2, 0);
    cpu_valid = 2'b01; cpu_addr[0] = A(2, 1);
    settle(); chk("R4 cpu0 blocked by fetch", cpu_ready, 2'b00);
    step();
    fetch_valid = 0;
    chk("R4 fetch reads single bank", fetch_rdata, 16'hBEEF);
    step(); clr();
    chk("R4 cpu0 read after stall", cpu_rdata[0], 16'hCAFE);
    fetch_valid = 1; fetch_addr = A(2, 5);
    settle(); step(); clr();
    chk("R2 untouched word in other bank", fetch_rdata, 16'h0000);
  endtask

  task automatic t_dma_path();
    dma_valid = 2'b11; dma_we = 2'b11;
    dma_addr[0] = A(0, 8); dma_wdata[0] = 16'h1111;
    dma_addr[1] = A(1, 8); dma_wdata[1] = 16'h2222;
    settle(); chk("R8 one DMA per dual group", dma_ready, 2'b01);
    step(); clr();
    chk("R9 drop pulse for loser", dma_drop, 2'b10);
    cpu_valid = 2'b01; cpu_addr[0] = A(1, 8);
    settle(); step(); clr();
    chk("R9 drop pulse one cycle", dma_drop, 2'b00);
    chk("R9 dropped write not stored", cpu_rdata[0], 16'h0000);
    dma_valid = 2'b11; dma_addr[0] = A(0, 8); dma_addr[1] = A(3, 0);
    settle(); chk("R8 separate group paths", dma_ready, 2'b11);
    step(); clr();
    chk("R8 dma reads", {dma_rvalid, dma_rdata[1], dma_rdata[0]}, {2'b11, 16'h5555, 16'h1111});
  endtask

  task automatic t_dma_lose();
    fetch_valid = 1; fetch_addr = A(2, 0);
    dma_valid = 2'b01; dma_addr[0] = A(2, 1);
    settle(); chk("R5 DMA below fetch", dma_ready, 2'b00);
    step(); clr();
    chk("R9 drop, no data", {dma_drop, dma_rvalid}, {2'b01, 2'b00});
    fetch_valid = 1; fetch_addr = A(0, 1);
    cpu_valid = 2'b01; cpu_addr[0] = A(0, 2);
    dma_valid = 2'b01; dma_we = 2'b01; dma_addr[0] = A(0, 3); dma_wdata[0] = 16'h9999;
    settle(); chk("R5 DMA below CPU on dual bank", dma_ready, 2'b00);
    step(); clr();
    chk("R9 drop after bank loss", dma_drop, 2'b01);
  endtask

  task automatic t_usb();
    usb_valid = 1; usb_we = 1; usb_addr = A(0, 9); usb_wdata = 16'hDEAD;
    settle(); chk("R10 usb to dual consumed", usb_ready, 1);
    step(); clr();
    chk("R10 reject pulse, no rvalid", {usb_reject, usb_rvalid}, 2'b10);
    cpu_valid = 2'b01; cpu_addr[0] = A(0, 9);
    settle(); step(); clr();
    chk("R10 rejected write not stored", cpu_rdata[0], 16'h0000);
    chk("R10 reject is one cycle", usb_reject, 0);
    cpu_valid = 2'b01; cpu_addr[0] = A(3, 1);
    usb_valid = 1; usb_we = 1; usb_addr = A(3, 7); usb_wdata = 16'h4242;
    settle(); chk("R5 usb below cpu", usb_ready, 0);
    step();
    cpu_valid = '0;
    settle(); chk("R5 held usb granted", usb_ready, 1);
    step(); clr();
    chk("R10 no reject on single bank", usb_reject, 0);
    usb_valid = 1; usb_addr = A(3, 7);
    settle(); step(); clr();
    chk("R2 usb read back", {usb_rvalid, usb_rdata}, {1'b1, 16'h4242});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    settle();
    t_reset();
    t_dual_two();
    t_phase_order();
    t_single();
    t_dma_path();
    t_dma_lose();
    t_usb();
    step();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule